// File: doc/BRIEF.md
# Two-Bank Atomic Set/Clear GPIO Controller

This block controls 32 general-purpose pins through a 32-bit register bus. The bus has an 8-bit address, a write strobe and a read strobe. The pins are split into a lower bank (pins 0-15) and an upper bank (pins 16-31). The upper bank uses the same register layout as the lower one, shifted up by 0x80. Inside a bank, a pin's bit position is its number modulo 16.

Each bank holds six per-pin feature registers: drive level, driver enable, open-drain mode, pull-up, pull-down and input enable. A feature register is never written as a plain value. The low half of the write word raises feature bits and the high half lowers them. Software can therefore change one pin's setting in a single bus write, with no read-modify-write and no race against another agent that owns a neighbouring pin.

Pin inputs pass through a multi-flop synchronizer before software can see them. A read-back register returns each synchronized level, masked by that pin's input enable. The feature registers drive the pad-control outputs directly.

Top module: `gpio_atomic_bank`

## Requirements
- R1: After reset every feature bit is 0, so pin_out, pin_oe, pin_od, pin_pu and pin_pd are all 0, and a read of any feature register returns 0.
- R2: A feature write with bit k (0-15) set and bit k+16 clear turns pin k of that bank's feature on. The new value shows on the outputs right after the clock edge that samples wr_en.
- R3: A feature write with bit k+16 set and bit k clear turns that pin's feature off, taking effect on the same edge.
- R4: A pin whose set bit and clear bit are both 1, or both 0, in a write keeps its feature value.
- R5: Address bit 7 selects the bank: 0 for pins 0-15 and 1 for pins 16-31. A write to one bank leaves every pin of the other bank unchanged.
- R6: Bank-relative offsets are 0x00 drive level (pin_out), 0x04 driver enable (pin_oe), 0x08 open-drain (pin_od), 0x18 pull-up (pin_pu), 0x1C pull-down (pin_pd) and 0x20 input enable. Each offset changes only its own feature.
- R7: A read of a feature offset returns that bank's feature bits in rdata[15:0] with rdata[31:16] = 0. rdata is valid in the cycle after the edge that samples rd_en, and holds until the next read.
- R8: A read of offset 0x30 returns, in bits 15:0, the bank's synchronized pin levels ANDed with input enable. A pin_in change first appears on a read whose strobe is sampled on the third rising edge after the change.
- R9: Writes to unmapped offsets, including the read-back offset 0x30, change nothing. Reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Byte address into the 256-byte window |
| wdata | input | 32 | Write word: low half sets bits, high half clears bits |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pad input levels |
| pin_out | output | 32 | Per-pin drive level |
| pin_oe | output | 32 | Per-pin driver enable |
| pin_od | output | 32 | Per-pin open-drain mode |
| pin_pu | output | 32 | Per-pin pull-up enable |
| pin_pd | output | 32 | Per-pin pull-down enable |

## Verification
The assertions assume that wr_en and rd_en are never high together on the same register. They also assume that addr and wdata are stable and known whenever a strobe is high. The read-back property further assumes that pin_in only changes well away from the reads that observe it. The stimulus drives every strobe for exactly one cycle, from the falling edge, and never issues a read and a write together. It changes pin_in only in dedicated phases, followed by at least two idle edges, except in the directed latency case, which deliberately reads on the edges right after a change.

// File: rtl/gpio_atomic_pkg.sv
package gpio_atomic_pkg;

   localparam int NUM_FEAT = 6;

   localparam int F_LVL = 0;
   localparam int F_DRV = 1;
   localparam int F_ODM = 2;
   localparam int F_PUP = 3;
   localparam int F_PDN = 4;
   localparam int F_INE = 5;

   localparam logic [7:0] OFS_LVL  = 8'h00;
   localparam logic [7:0] OFS_DRV  = 8'h04;
   localparam logic [7:0] OFS_ODM  = 8'h08;
   localparam logic [7:0] OFS_PUP  = 8'h18;
   localparam logic [7:0] OFS_PDN  = 8'h1C;
   localparam logic [7:0] OFS_INE  = 8'h20;
   localparam logic [7:0] OFS_RDBK = 8'h30;

   function automatic logic [NUM_FEAT-1:0] feat_decode(input logic [7:0] ofs);
      logic [NUM_FEAT-1:0] hot;
      hot = '0;
      case (ofs)
         OFS_LVL: hot[F_LVL] = 1'b1;
         OFS_DRV: hot[F_DRV] = 1'b1;
         OFS_ODM: hot[F_ODM] = 1'b1;
         OFS_PUP: hot[F_PUP] = 1'b1;
         OFS_PDN: hot[F_PDN] = 1'b1;
         OFS_INE: hot[F_INE] = 1'b1;
         default: hot = '0;
      endcase
      return hot;
   endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
   parameter int WIDTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [WIDTH-1:0] set_bits,
   input  logic [WIDTH-1:0] clr_bits,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] raise_m;
   logic [WIDTH-1:0] lower_m;

   assign raise_m = set_bits & ~clr_bits;
   assign lower_m = clr_bits & ~set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (we) begin
         q <= (q | raise_m) & ~lower_m;
      end
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else begin
            chain[s] <= (s == 0) ? d : chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_atomic_pkg::*;
#(
   parameter int BANK_PINS = 16
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 we,
   input  logic [7:0]                           ofs,
   input  logic [2*BANK_PINS-1:0]               wdata,
   input  logic [BANK_PINS-1:0]                 pin_sync,
   output logic [NUM_FEAT-1:0][BANK_PINS-1:0]   feat_q,
   output logic [BANK_PINS-1:0]                 rd_word
);

   logic [NUM_FEAT-1:0] dec;
   logic [NUM_FEAT-1:0] hit;

   assign dec = feat_decode(ofs);
   assign hit = we ? dec : '0;

   for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
      gpio_setclr_reg #(
         .WIDTH (BANK_PINS)
      ) u_reg (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (hit[f]),
         .set_bits (wdata[BANK_PINS-1:0]),
         .clr_bits (wdata[2*BANK_PINS-1:BANK_PINS]),
         .q        (feat_q[f])
      );
   end

   always_comb begin
      rd_word = '0;
      if (ofs == OFS_RDBK) begin
         rd_word = pin_sync & feat_q[F_INE];
      end else begin
         for (int f = 0; f < NUM_FEAT; f++) begin
            if (dec[f]) begin
               rd_word = feat_q[f];
            end
         end
      end
   end

endmodule

// File: rtl/gpio_atomic_bank.sv
module gpio_atomic_bank
   import gpio_atomic_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int BANK_PINS   = 16,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   input  logic                wr_en,
   input  logic                rd_en,
   output logic [DATA_W-1:0]   rdata,
   input  logic [NUM_PINS-1:0] pin_in,
   output logic [NUM_PINS-1:0] pin_out,
   output logic [NUM_PINS-1:0] pin_oe,
   output logic [NUM_PINS-1:0] pin_od,
   output logic [NUM_PINS-1:0] pin_pu,
   output logic [NUM_PINS-1:0] pin_pd
);

   localparam int NUM_BANKS = NUM_PINS / BANK_PINS;
   localparam int BSEL_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
   localparam int OFS_W     = ADDR_W - BSEL_W;

   if (NUM_BANKS * BANK_PINS != NUM_PINS || NUM_BANKS < 2 ||
       (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("gpio_atomic_bank: NUM_PINS must be a power-of-two multiple (>=2) of BANK_PINS");
   end
   if (DATA_W != 2 * BANK_PINS) begin : g_bad_data
      $error("gpio_atomic_bank: DATA_W must equal twice BANK_PINS");
   end
   if (OFS_W < 6 || OFS_W > 8) begin : g_bad_addr
      $error("gpio_atomic_bank: bank offset field must be 6 to 8 bits wide");
   end

   logic [BSEL_W-1:0]                                 bsel;
   logic [7:0]                                        ofs;
   logic [NUM_PINS-1:0]                               pin_sync;
   logic [NUM_BANKS-1:0][NUM_FEAT-1:0][BANK_PINS-1:0] feat_all;
   logic [NUM_BANKS-1:0][BANK_PINS-1:0]               bank_rd;

   assign bsel = addr[ADDR_W-1 -: BSEL_W];
   assign ofs  = 8'(addr[OFS_W-1:0]);

   gpio_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      logic bank_we;
      assign bank_we = wr_en && (bsel == BSEL_W'(g));

      gpio_bank #(
         .BANK_PINS (BANK_PINS)
      ) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (bank_we),
         .ofs      (ofs),
         .wdata    (wdata),
         .pin_sync (pin_sync[g*BANK_PINS +: BANK_PINS]),
         .feat_q   (feat_all[g]),
         .rd_word  (bank_rd[g])
      );

      assign pin_out[g*BANK_PINS +: BANK_PINS] = feat_all[g][F_LVL];
      assign pin_oe [g*BANK_PINS +: BANK_PINS] = feat_all[g][F_DRV];
      assign pin_od [g*BANK_PINS +: BANK_PINS] = feat_all[g][F_ODM];
      assign pin_pu [g*BANK_PINS +: BANK_PINS] = feat_all[g][F_PUP];
      assign pin_pd [g*BANK_PINS +: BANK_PINS] = feat_all[g][F_PDN];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= DATA_W'(bank_rd[bsel]);
      end
   end

endmodule

// File: rtl/gpio_atomic_bank_chk.sv
module gpio_atomic_bank_chk #(
   parameter int NUM_PINS    = 32,
   parameter int BANK_PINS   = 16,
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   addr,
   input logic [DATA_W-1:0]   wdata,
   input logic                wr_en,
   input logic                rd_en,
   input logic [DATA_W-1:0]   rdata,
   input logic [NUM_PINS-1:0] pin_in,
   input logic [NUM_PINS-1:0] pin_out,
   input logic [NUM_PINS-1:0] pin_oe,
   input logic [NUM_PINS-1:0] pin_od,
   input logic [NUM_PINS-1:0] pin_pu,
   input logic [NUM_PINS-1:0] pin_pd
);

   localparam int BP = BANK_PINS;

   logic [BP-1:0] raise_w;
   logic [BP-1:0] lower_w;
   logic          mapped;
   logic [6:0]    ofs7;

   assign raise_w = wdata[BP-1:0] & ~wdata[2*BP-1:BP];
   assign lower_w = wdata[2*BP-1:BP] & ~wdata[BP-1:0];
   assign ofs7    = addr[6:0];
   assign mapped  = (ofs7 == 7'h00) || (ofs7 == 7'h04) || (ofs7 == 7'h08) ||
                    (ofs7 == 7'h18) || (ofs7 == 7'h1C) || (ofs7 == 7'h20) ||
                    (ofs7 == 7'h30);

   // R1: first edge out of reset still sees every control output low
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_out == '0 && pin_oe == '0 && pin_od == '0 &&
                        pin_pu == '0 && pin_pd == '0));

   // R2: raised driver-enable bits in the lower bank are on after the write edge
   assert_raise_drv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(8'h04)) |=>
      ((pin_oe[BP-1:0] & $past(raise_w)) == $past(raise_w)));

   // R3: lowered drive-level bits in the upper bank are off after the write edge
   assert_lower_lvl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(8'h80)) |=>
      ((pin_out[2*BP-1:BP] & $past(lower_w)) == '0));

   // R4: with no write, nothing on the control outputs moves
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pin_out) && $stable(pin_oe) && $stable(pin_od) &&
                  $stable(pin_pu) && $stable(pin_pd)));

   // R7: upper half of read data is always zero after a read
   assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (rdata[DATA_W-1:BP] == '0));

   // R9: unmapped reads return zero
   assert_unmapped_rd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !mapped) |=> (rdata == '0));

   // R9: unmapped writes leave all control outputs untouched
   assert_unmapped_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> ($stable(pin_out) && $stable(pin_oe) &&
                              $stable(pin_od) && $stable(pin_pu) && $stable(pin_pd)));

endmodule

bind gpio_atomic_bank gpio_atomic_bank_chk #(
   .NUM_PINS    (NUM_PINS),
   .BANK_PINS   (BANK_PINS),
   .ADDR_W      (ADDR_W),
   .DATA_W      (DATA_W),
   .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/gpio_atomic_bank_bench.sv
module gpio_atomic_bank_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [31:0] rdata;
   logic [31:0] pin_in = '0;
   logic [31:0] pin_out, pin_oe, pin_od, pin_pu, pin_pd;

   int total = 0;
   int bad   = 0;

   // model: 0 lvl, 1 drv, 2 odm, 3 pup, 4 pdn, 5 ine
   logic [31:0] m_feat [6];

   always #5 clk = ~clk;

   gpio_atomic_bank u_gpio_atomic_bank (
      .clk, .rst_n, .addr, .wdata, .wr_en, .rd_en, .rdata,
      .pin_in, .pin_out, .pin_oe, .pin_od, .pin_pu, .pin_pd
   );

   function automatic int feat_idx(input logic [6:0] o);
      case (o)
         7'h00: return 0;
         7'h04: return 1;
         7'h08: return 2;
         7'h18: return 3;
         7'h1C: return 4;
         7'h20: return 5;
         default: return -1;
      endcase
   endfunction

   function automatic logic [15:0] upd16(input logic [15:0] q, input logic [31:0] w);
      return (q | (w[15:0] & ~w[31:16])) & ~(w[31:16] & ~w[15:0]);
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      int b;
      int f;
      b = a[7] ? 16 : 0;
      f = feat_idx(a[6:0]);
      if (a[6:0] == 7'h30) return {16'h0, pin_in[b +: 16] & m_feat[5][b +: 16]};
      if (f < 0) return 32'h0;
      return {16'h0, m_feat[f][b +: 16]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_outs(input string tag);
      chk({tag, " pin_out"}, pin_out, m_feat[0]);
      chk({tag, " pin_oe"},  pin_oe,  m_feat[1]);
      chk({tag, " pin_od"},  pin_od,  m_feat[2]);
      chk({tag, " pin_pu"},  pin_pu,  m_feat[3]);
      chk({tag, " pin_pd"},  pin_pd,  m_feat[4]);
   endtask

   // tasks are entered at a falling edge and leave at a falling edge
   task automatic do_write(input logic [7:0] a, input logic [31:0] w);
      int f;
      int b;
      addr = a; wdata = w; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      f = feat_idx(a[6:0]);
      b = a[7] ? 16 : 0;
      if (f >= 0) m_feat[f][b +: 16] = upd16(m_feat[f][b +: 16], w);
   endtask

   task automatic do_read(input logic [7:0] a, output logic [31:0] r);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      r = rdata;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      logic [31:0] r;
      logic [7:0]  ofs_tab [9];
      void'($urandom(32'd20240611));
      ofs_tab = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h30, 8'h0C, 8'h7C};
      for (int i = 0; i < 6; i++) m_feat[i] = '0;

      repeat (3) @(negedge clk);
      chk_outs("R1 in reset");
      chk("R1 rdata in reset", rdata, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_outs("R1 after reset");
      do_read(8'h04, r); chk("R1 read drv", r, 32'h0);
      do_read(8'hA0, r); chk("R1 read ine hi", r, 32'h0);

      // R2 set, R3 clear
      do_write(8'h04, 32'h0000_0008);
      chk("R2 pin_oe set", pin_oe, 32'h0000_0008);
      do_write(8'h04, 32'h0008_0000);
      chk("R3 pin_oe clear", pin_oe, 32'h0);

      // R4 both and neither
      do_write(8'h00, 32'h0000_FFFF);
      do_write(8'h00, 32'hFFFF_FFFF);
      chk("R4 both set hold", pin_out, 32'h0000_FFFF);
      do_write(8'h00, 32'h0000_0000);
      chk("R4 zero hold", pin_out, 32'h0000_FFFF);
      do_write(8'h00, 32'h0001_0002);
      chk("R4 mixed", pin_out, 32'h0000_FFFE);

      // R5 upper bank
      do_write(8'h80, 32'h0000_0001);
      chk("R5 upper bank pin16", pin_out, 32'h0001_FFFE);
      do_write(8'h84, 32'h0000_8000);
      chk("R5 upper drv pin31", pin_oe, 32'h8000_0000);

      // R6 each offset reaches only its own output
      do_write(8'h08, 32'h0000_0010);
      do_write(8'h18, 32'h0000_0020);
      do_write(8'h1C, 32'h0000_0040);
      do_write(8'h20, 32'h0000_00FF);
      chk_outs("R6 offset map");
      chk("R6 pu only bit5", pin_pu, 32'h0000_0020);

      // R7 register reads
      do_read(8'h00, r); chk("R7 read lvl", r, 32'h0000_FFFE);
      do_read(8'h80, r); chk("R7 read lvl hi", r, 32'h0000_0001);
      do_read(8'h20, r); chk("R7 read ine", r, 32'h0000_00FF);
      @(negedge clk);
      chk("R7 rdata holds", rdata, 32'h0000_00FF);

      // R8 read-back mask and latency
      pin_in = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      do_read(8'h30, r); chk("R8 rdbk masked", r, 32'h0000_00FF);
      do_read(8'hB0, r); chk("R8 rdbk hi ine off", r, 32'h0);
      pin_in = 32'h0;
      do_read(8'h30, r); chk("R8 latency edge1", r, 32'h0000_00FF);
      do_read(8'h30, r); chk("R8 latency edge2", r, 32'h0000_00FF);
      do_read(8'h30, r); chk("R8 latency edge3", r, 32'h0);

      // R9 unmapped and read-back writes ignored
      do_write(8'h0C, 32'h0000_FFFF);
      do_write(8'h30, 32'h0000_FFFF);
      do_write(8'hFC, 32'hFFFF_0000);
      chk_outs("R9 unmapped write");
      do_read(8'h20, r); chk("R9 ine untouched", r, 32'h0000_00FF);
      do_read(8'h0C, r); chk("R9 unmapped read", r, 32'h0);

      // random phase
      for (int it = 0; it < 600; it++) begin
         logic [7:0]  a;
         logic [31:0] w;
         int          sel;
         if (it % 40 == 0) begin
            pin_in = $urandom;
            repeat (3) @(negedge clk);
         end
         a = {1'($urandom), ofs_tab[$urandom % 9][6:0]};
         sel = $urandom % 4;
         w = (sel == 0) ? (32'h1 << ($urandom % 32)) : $urandom;
         if ($urandom % 2) begin
            do_write(a, w);
            chk_outs("R2 R3 R4 R5 R6 R9 random write");
         end else begin
            do_read(a, r);
            chk("R7 R8 R9 random read", r, exp_read(a));
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule